// File: doc/BRIEF.md
# Bit-Reversed Write Address Generator

This block computes write addresses that put data into the scrambled order a radix-2 FFT needs. For each request it takes a byte-address pointer, a pivot value measured in words, and a few qualifiers: an enable, a pointer-register select, an addressing mode and a byte/word flag. It returns the effective address, the next pointer value and a write-back strobe. Results are registered, so they appear one clock after the request.

Bit-reversed stepping applies only when every qualifier holds. The enable must be set. The select must not hold its reserved all-ones code. The mode must be pre-increment or post-increment. The access must be a word. In that case the word index of the pointer is added to the pivot with carries running from high bits toward low bits. The normal increment is not used. The result is scaled back to a byte address with bit 0 clear. In every other case the block does ordinary pointer arithmetic. Bit-reversed stepping also masks a modulo-correction request for the same access.

To build a buffer of 2^N words, align its start to 2^(N+1) bytes, set the pivot to 2^(N-1) and start the pointer at the buffer start. Successive writes then land in bit-reversed index order.

Top module: `brev_wagen`

## Requirements
- R1: The reset state is `out_vld`, `out_ea`, `out_ptr`, `out_wb`, `out_brev` and `out_modulo` all zero. Each output reflects the request sampled on the previous rising clock edge, and `out_vld` equals the previous cycle's `req_vld`.
- R2: Bit-reversed stepping (`out_brev`=1) happens only when all of these hold: `brev_en`=1, `ptr_sel` is not 15, `is_byte`=0, and `amode` is 2 (post-increment) or 4 (pre-increment).
- R3: When bit-reversed stepping is active, the next pointer is {S, 1'b0}. S is the reverse-carry sum of `ptr_in[15:1]` and `pivot`: both are bit-mirrored, added modulo 2^15, and the sum is mirrored back. The normal step size plays no part.
- R4: In post-increment bit-reversed stepping, `out_ea` is `ptr_in` with bit 0 cleared, `out_ptr` is the reverse-carry result, and `out_wb`=1.
- R5: In pre-increment bit-reversed stepping, `out_ea` and `out_ptr` both equal the reverse-carry result, and `out_wb`=1.
- R6: Whenever `out_brev`=1, bit 0 of `out_ea` and bit 0 of `out_ptr` are 0, even for an odd `ptr_in`.
- R7: In fallback the step is 1 for bytes and 2 for words. The modes behave as follows:
  - mode 1 (post-decrement): ea=ptr, next=ptr-step.
  - mode 2 (post-increment): ea=ptr, next=ptr+step.
  - mode 3 (pre-decrement): ea=next=ptr-step.
  - mode 4 (pre-increment): ea=next=ptr+step.
  - In each of modes 1 to 4, `out_wb`=1.
  - mode 0 and modes 5 to 7: ea=ptr, next=ptr, `out_wb`=0.
- R8: `out_modulo` equals the sampled `modulo_en` with bit-reversed stepping inactive. Bit-reversed stepping takes priority and forces it to 0.
- R9: Start with a pointer aligned to 2^(N+1) bytes and pivot 2^(N-1), using post-increment word writes, and feed `out_ptr` back each time. The 2^N effective addresses are then base + 2*rev_N(k), and the pointer returns to base after 2^N writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_vld | input | 1 | Request present this cycle |
| ptr_in | input | 16 | Current pointer (byte address) |
| pivot | input | 15 | Pivot modifier in words |
| brev_en | input | 1 | Bit-reversed stepping enable |
| ptr_sel | input | 4 | Pointer-register select; 15 is reserved |
| amode | input | 3 | Addressing mode code |
| is_byte | input | 1 | 1 = byte access, 0 = word access |
| modulo_en | input | 1 | Modulo correction requested |
| out_vld | output | 1 | Registered request valid |
| out_ea | output | 16 | Effective address |
| out_ptr | output | 16 | Updated pointer value |
| out_wb | output | 1 | Pointer write-back strobe |
| out_brev | output | 1 | Bit-reversed stepping was used |
| out_modulo | output | 1 | Modulo correction allowed for this access |

## Verification
The assertions that use `$past` assume the request fields are meaningful only in a cycle where `req_vld` is high. They therefore compare registered outputs only against inputs sampled in a cycle that had a request. The bench drives every field on the falling edge and holds it through the next rising edge. It also feeds each sweep step from the pointer the block has just produced. The sweep relies on the alignment rule: each base address is chosen with its low N+1 bits clear, so the reverse-carry walk stays inside the buffer.

// File: rtl/brev_pkg.sv
package brev_pkg;
  typedef enum logic [2:0] {
    AM_DIRECT  = 3'd0,
    AM_POSTDEC = 3'd1,
    AM_POSTINC = 3'd2,
    AM_PREDEC  = 3'd3,
    AM_PREINC  = 3'd4
  } amode_e;
endpackage

// File: rtl/brev_qual.sv
module brev_qual
  import brev_pkg::*;
#(
  parameter int SW = 4
) (
  input  logic          brev_en,
  input  logic [SW-1:0] ptr_sel,
  input  logic [2:0]    amode,
  input  logic          is_byte,
  output logic          rev_act,
  output logic          rev_pre
);
  localparam logic [SW-1:0] RSVD_SEL = {SW{1'b1}};

  logic mode_ok;
  logic sel_ok;

  always_comb begin
    sel_ok  = (ptr_sel != RSVD_SEL);
    mode_ok = (amode == AM_POSTINC) || (amode == AM_PREINC);
    rev_act = brev_en && sel_ok && mode_ok && !is_byte;
    rev_pre = (amode == AM_PREINC);
  end
endmodule

// File: rtl/brev_calc.sv
module brev_calc
  import brev_pkg::*;
#(
  parameter int AW = 16,
  parameter int MW = 15
) (
  input  logic [AW-1:0] ptr_in,
  input  logic [MW-1:0] pivot,
  input  logic [2:0]    amode,
  input  logic          is_byte,
  input  logic          rev_act,
  input  logic          rev_pre,
  output logic [AW-2:0] rc_sum,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] nptr,
  output logic          wb
);
  localparam int IW = AW - 1;

  function automatic logic [IW-1:0] mirror(input logic [IW-1:0] v);
    logic [IW-1:0] r;
    for (int i = 0; i < IW; i++) r[i] = v[IW-1-i];
    return r;
  endfunction

  function automatic logic [IW-1:0] rc_add(input logic [IW-1:0] a, input logic [IW-1:0] b);
    return mirror(mirror(a) + mirror(b));
  endfunction

  logic [IW-1:0] piv_ext;
  logic [AW-1:0] step;
  logic [AW-1:0] up;
  logic [AW-1:0] dn;
  logic [AW-1:0] rev_addr;

  always_comb begin
    piv_ext = '0;
    piv_ext[MW-1:0] = pivot;
    rc_sum   = rc_add(ptr_in[AW-1:1], piv_ext);
    rev_addr = {rc_sum, 1'b0};
    step     = is_byte ? AW'(1) : AW'(2);
    up       = ptr_in + step;
    dn       = ptr_in - step;
    ea   = ptr_in;
    nptr = ptr_in;
    wb   = 1'b0;
    if (rev_act) begin
      nptr = rev_addr;
      ea   = rev_pre ? rev_addr : {ptr_in[AW-1:1], 1'b0};
      wb   = 1'b1;
    end else begin
      case (amode)
        AM_POSTDEC: begin nptr = dn; wb = 1'b1; end
        AM_POSTINC: begin nptr = up; wb = 1'b1; end
        AM_PREDEC:  begin nptr = dn; ea = dn; wb = 1'b1; end
        AM_PREINC:  begin nptr = up; ea = up; wb = 1'b1; end
        default:    begin nptr = ptr_in; ea = ptr_in; wb = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/brev_wagen.sv
module brev_wagen #(
  parameter int AW = 16,
  parameter int MW = 15,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic [AW-1:0] ptr_in,
  input  logic [MW-1:0] pivot,
  input  logic          brev_en,
  input  logic [SW-1:0] ptr_sel,
  input  logic [2:0]    amode,
  input  logic          is_byte,
  input  logic          modulo_en,
  output logic          out_vld,
  output logic [AW-1:0] out_ea,
  output logic [AW-1:0] out_ptr,
  output logic          out_wb,
  output logic          out_brev,
  output logic          out_modulo
);
  logic          rev_act;
  logic          rev_pre;
  logic [AW-2:0] rc_sum;
  logic [AW-1:0] ea_d;
  logic [AW-1:0] nptr_d;
  logic          wb_d;

  brev_qual #(.SW(SW)) u_qual (
    .brev_en(brev_en), .ptr_sel(ptr_sel), .amode(amode), .is_byte(is_byte),
    .rev_act(rev_act), .rev_pre(rev_pre)
  );

  brev_calc #(.AW(AW), .MW(MW)) u_calc (
    .ptr_in(ptr_in), .pivot(pivot), .amode(amode), .is_byte(is_byte),
    .rev_act(rev_act), .rev_pre(rev_pre), .rc_sum(rc_sum),
    .ea(ea_d), .nptr(nptr_d), .wb(wb_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld    <= 1'b0;
      out_ea     <= '0;
      out_ptr    <= '0;
      out_wb     <= 1'b0;
      out_brev   <= 1'b0;
      out_modulo <= 1'b0;
    end else begin
      out_vld    <= req_vld;
      out_ea     <= ea_d;
      out_ptr    <= nptr_d;
      out_wb     <= wb_d;
      out_brev   <= rev_act;
      out_modulo <= modulo_en && !rev_act;
    end
  end
endmodule

// File: rtl/brev_chk.sv
module brev_chk #(
  parameter int AW = 16,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_vld,
  input logic [AW-1:0] ptr_in,
  input logic          brev_en,
  input logic [SW-1:0] ptr_sel,
  input logic [2:0]    amode,
  input logic          is_byte,
  input logic          out_vld,
  input logic [AW-1:0] out_ea,
  input logic [AW-1:0] out_ptr,
  input logic          out_wb,
  input logic          out_brev,
  input logic          out_modulo
);
  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(req_vld));
  // R2
  qual_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_brev) |-> ($past(brev_en) && !$past(is_byte) && ($past(ptr_sel) != {SW{1'b1}})));
  // R4
  post_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_brev && $past(amode) == 3'd2) |-> (out_ea == {$past(ptr_in[AW-1:1]), 1'b0}));
  // R5
  pre_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_brev && $past(amode) == 3'd4) |-> (out_ea == out_ptr));
  // R6
  lsb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_brev) |-> (!out_ea[0] && !out_ptr[0] && out_wb));
  // R8
  modulo_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_modulo |-> !out_brev);
endmodule

bind brev_wagen brev_chk #(.AW(AW), .SW(SW)) u_brev_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .ptr_in(ptr_in),
  .brev_en(brev_en), .ptr_sel(ptr_sel), .amode(amode), .is_byte(is_byte),
  .out_vld(out_vld), .out_ea(out_ea), .out_ptr(out_ptr), .out_wb(out_wb),
  .out_brev(out_brev), .out_modulo(out_modulo)
);

// File: tb/test_brev_wagen.sv
module test_brev_wagen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic [15:0] ptr_in = '0;
  logic [14:0] pivot = '0;
  logic        brev_en = 1'b0;
  logic [3:0]  ptr_sel = '0;
  logic [2:0]  amode = '0;
  logic        is_byte = 1'b0;
  logic        modulo_en = 1'b0;
  logic        out_vld, out_wb, out_brev, out_modulo;
  logic [15:0] out_ea, out_ptr;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brev_wagen i_brev_wagen (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .ptr_in(ptr_in), .pivot(pivot),
    .brev_en(brev_en), .ptr_sel(ptr_sel), .amode(amode), .is_byte(is_byte),
    .modulo_en(modulo_en), .out_vld(out_vld), .out_ea(out_ea), .out_ptr(out_ptr),
    .out_wb(out_wb), .out_brev(out_brev), .out_modulo(out_modulo)
  );

  // reverse-carry add: carry travels from MSB toward LSB
  function automatic logic [14:0] ref_rc(input logic [14:0] a, input logic [14:0] b);
    logic [14:0] s;
    logic c;
    c = 1'b0;
    for (int i = 14; i >= 0; i--) begin
      s[i] = a[i] ^ b[i] ^ c;
      c = (a[i] & b[i]) | (a[i] & c) | (b[i] & c);
    end
    return s;
  endfunction

  function automatic int rev_n(input int k, input int n);
    int r;
    r = 0;
    for (int i = 0; i < n; i++) if (k & (1 << i)) r = r | (1 << (n - 1 - i));
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] p, input logic [14:0] pv, input logic en,
                       input logic [3:0] sel, input logic [2:0] m, input logic b, input logic mo);
    @(negedge clk);
    req_vld = 1'b1; ptr_in = p; pivot = pv; brev_en = en; ptr_sel = sel;
    amode = m; is_byte = b; modulo_en = mo;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 vld", {31'd0, out_vld}, 0);
    check("R1 ea", {16'd0, out_ea}, 0);
    check("R1 ptr", {16'd0, out_ptr}, 0);
    check("R1 flags", {29'd0, out_wb, out_brev, out_modulo}, 0);
  endtask

  task automatic t_sweep(input logic [15:0] base, input int n);
    logic [15:0] p;
    p = base;
    for (int k = 0; k < (1 << n); k++) begin
      apply(p, 15'(1 << (n - 1)), 1'b1, 4'd3, 3'd2, 1'b0, 1'b0);
      check("R9 sweep ea", {16'd0, out_ea}, {16'd0, base + 16'(2 * rev_n(k, n))});
      check("R4 post ptr", {16'd0, out_ptr}, {16'd0, ref_rc(p[15:1], 15'(1 << (n - 1))), 1'b0});
      check("R1 vld", {31'd0, out_vld}, 1);
      p = out_ptr;
    end
    check("R9 wrap", {16'd0, p}, {16'd0, base});
  endtask

  task automatic t_pre();
    logic [15:0] e;
    e = {ref_rc(15'h00A3, 15'h0140), 1'b0};
    apply(16'h0147, 15'h0140, 1'b1, 4'd0, 3'd4, 1'b0, 1'b0);
    check("R5 pre ea", {16'd0, out_ea}, {16'd0, e});
    check("R5 pre ptr", {16'd0, out_ptr}, {16'd0, e});
    check("R3 wb brev", {30'd0, out_wb, out_brev}, 3);
  endtask

  task automatic t_odd();
    apply(16'h0201, 15'h4000, 1'b1, 4'd1, 3'd2, 1'b0, 1'b0);
    check("R6 ea lsb", {16'd0, out_ea}, 32'h0200);
    check("R6 ptr", {16'd0, out_ptr}, {16'd0, ref_rc(15'h0100, 15'h4000), 1'b0});
  endtask

  task automatic t_fallback();
    apply(16'h1000, 15'h0008, 1'b1, 4'd2, 3'd2, 1'b1, 1'b0);
    check("R2 byte", {15'd0, out_brev, out_ptr}, 32'h1001);
    check("R7 byte ea", {16'd0, out_ea}, 32'h1000);
    apply(16'h1000, 15'h0008, 1'b1, 4'd15, 3'd2, 1'b0, 1'b0);
    check("R2 sel15", {15'd0, out_brev, out_ptr}, 32'h1002);
    apply(16'h1000, 15'h0008, 1'b0, 4'd2, 3'd4, 1'b0, 1'b0);
    check("R2 off pre", {15'd0, out_brev, out_ptr}, 32'h1002);
    check("R7 preinc ea", {16'd0, out_ea}, 32'h1002);
    apply(16'h1000, 15'h0008, 1'b1, 4'd2, 3'd3, 1'b0, 1'b0);
    check("R7 predec", {15'd0, out_brev, out_ea}, 32'h0FFE);
    check("R7 predec wb", {31'd0, out_wb}, 1);
    apply(16'h1000, 15'h0008, 1'b1, 4'd2, 3'd1, 1'b1, 1'b0);
    check("R7 postdec", {out_ea, out_ptr}, 32'h10000FFF);
    apply(16'h1001, 15'h0008, 1'b1, 4'd2, 3'd0, 1'b0, 1'b0);
    check("R7 direct", {out_ea, out_ptr}, 32'h10011001);
    check("R7 direct wb", {30'd0, out_wb, out_brev}, 0);
    apply(16'h1001, 15'h0008, 1'b1, 4'd2, 3'd6, 1'b0, 1'b0);
    check("R7 unused mode", {14'd0, out_wb, out_brev, out_ptr}, 32'h1001);
  endtask

  task automatic t_modulo();
    apply(16'h0040, 15'h0004, 1'b1, 4'd2, 3'd2, 1'b0, 1'b1);
    check("R8 masked", {30'd0, out_brev, out_modulo}, 2);
    apply(16'h0040, 15'h0004, 1'b0, 4'd2, 3'd2, 1'b0, 1'b1);
    check("R8 pass", {30'd0, out_brev, out_modulo}, 1);
    @(negedge clk);
    check("R1 idle vld", {31'd0, out_vld}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_sweep(16'h0140, 4);
    t_sweep(16'h0800, 3);
    t_pre();
    t_odd();
    t_fallback();
    t_modulo();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule